// File: doc/BRIEF.md
# Interrupt Controller Command Register Port

This block is the byte-wide programming port of a single eight-line interrupt controller. Software reaches it through a one-bit address. Address 0 accepts the start-of-setup word and the operational commands. Address 1 carries the setup data words and, in normal operation, the mask. The block holds the state the rest of the controller reads: the request, in-service and mask registers, the rotating priority offset, the vector base, and the mode flags for auto end-of-interrupt, rotation, fully nested operation and special mask.

Request bits come in as set pulses from the trigger logic (`req_set`). In-service bits come in as set pulses from the acknowledge logic (`svc_set`). The current winner of the external priority resolver arrives on `res_valid`/`res_line`. A poll read consumes that winner. Read data is combinational and valid in the cycle `rd_en` is high. All state updates at the following clock edge. When one edge both sets and clears the same request or in-service bit, the clear wins. A setup word clears everything, including bits set in the same cycle.

Top module: `picr_cmd_port`

## Requirements
- R1: After reset, request, in-service and mask are 0, the offset is 0, the vector base is 0, all mode flags are 0, `cfg_busy` is 0, and a read of address 0 returns the request register.
- R2: A write to address 0 with bit 4 set clears the request, in-service and mask registers, the offset, the vector base, the read select, the poll flag and all mode flags. It stores bit 0 as "fourth word wanted", raises `cfg_busy`, and pulses `int_drop` for the following cycle.
- R3: While `cfg_busy` is high, address 1 writes do not touch the mask. The first such write stores the vector base as data AND 0xF8. The second ends setup unless a fourth word is wanted. The fourth word sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, then ends setup.
- R4: With `cfg_busy` low, an address 1 write loads the mask register.
- R5: An address 0 write with bit 4 clear and bit 3 set is a mode word. Bit 2 arms a poll. Bit 1 set makes bit 0 the read select (1 selects in-service, 0 selects request). Bit 6 set makes bit 5 the new `special_mask`.
- R6: An address 0 write with bits 4 and 3 clear is a command with code data[7:5]. Code 0 clears `rot_on_aeoi` and code 4 sets it. Code 2 changes nothing.
- R7: Code 1 clears the highest-priority in-service bit. Priority runs from line `prio_off` upward, modulo 8. With an empty in-service register, codes 1 and 5 change no state.
- R8: Code 5 acts as code 1 and also sets the offset to (cleared line + 1) mod 8.
- R9: Code 3 clears the in-service bit named by data[2:0]. Code 6 sets the offset to (data[2:0] + 1) mod 8. Code 7 clears the named in-service bit and sets the offset to (data[2:0] + 1) mod 8.
- R10: With no poll armed, a read of address 0 returns the register chosen by the read select, and a read of address 1 returns the mask.
- R11: With a poll armed, a read at either address returns `res_line` when `res_valid` is high and clears that line's request and in-service bits. With `res_valid` low it returns 7. Either way it disarms the poll.
- R12: `req_set` bits set request bits and `svc_set` bits set in-service bits. Those bits stay set until a clear named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| req_set | input | 8 | Request set pulses |
| svc_set | input | 8 | In-service set pulses |
| res_valid | input | 1 | Resolver has a winner |
| res_line | input | 3 | Resolver winning line |
| irr | output | 8 | Request register |
| isr | output | 8 | In-service register |
| imr | output | 8 | Mask register |
| prio_off | output | 3 | Lowest-numbered line of the rotating priority order |
| vec_base | output | 8 | Vector base |
| nested_mode | output | 1 | Fully nested mode |
| auto_eoi | output | 1 | Auto end-of-interrupt |
| rot_on_aeoi | output | 1 | Rotate on auto end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| cfg_busy | output | 1 | Setup sequence in progress |
| int_drop | output | 1 | One-cycle pulse after a setup start |

## Verification
The hardest state to reach is a non-specific end-of-interrupt that must pick a bit while several in-service bits are set and the offset has already been rotated past some of them. That needs earlier rotating commands, in-service pulses and no setup word in between. The stimulus mixes sparse random `svc_set` pulses with frequent random command words and rare setup words. The offset and the in-service register therefore drift through many combinations. Directed steps cover the empty-register case, the 4-word setup and a poll with nothing pending.

// File: rtl/picr_pkg.sv
package picr_pkg;
  localparam int NL = 8;
  localparam int LW = $clog2(NL);
  localparam int DW = 8;
  localparam logic [DW-1:0] BASE_KEEP = 8'hF8;

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_W3, ST_W4} init_st_e;

  typedef enum logic [3:0] {
    OP_NONE, OP_INIT, OP_MODE, OP_ROT_CLR, OP_ROT_SET, OP_EOI, OP_EOI_ROT,
    OP_SEOI, OP_SETPRI, OP_SEOI_ROT, OP_DATA
  } op_e;

  typedef struct packed {
    logic          hit;
    logic [LW-1:0] line;
  } pick_t;

  // highest-priority set bit, priority starting at line 'off'
  function automatic pick_t hi_pick(logic [NL-1:0] bits, logic [LW-1:0] off);
    pick_t r;
    logic [LW-1:0] l;
    r = '0;
    for (int p = NL - 1; p >= 0; p--) begin
      l = off + LW'(p);
      if (bits[l]) begin
        r.hit  = 1'b1;
        r.line = l;
      end
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] past_line(logic [LW-1:0] line);
    return line + LW'(1);
  endfunction

  function automatic logic [NL-1:0] line_bit(logic [LW-1:0] line);
    return NL'(1) << line;
  endfunction
endpackage

// File: rtl/picr_decode.sv
module picr_decode
  import picr_pkg::*;
(
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output op_e           op
);
  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if (addr)          op = OP_DATA;
      else if (wdata[4]) op = OP_INIT;
      else if (wdata[3]) op = OP_MODE;
      else begin
        unique case (wdata[7:5])
          3'd0:    op = OP_ROT_CLR;
          3'd1:    op = OP_EOI;
          3'd3:    op = OP_SEOI;
          3'd4:    op = OP_ROT_SET;
          3'd5:    op = OP_EOI_ROT;
          3'd6:    op = OP_SETPRI;
          3'd7:    op = OP_SEOI_ROT;
          default: op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/picr_isr_pick.sv
module picr_isr_pick
  import picr_pkg::*;
(
  input  logic [NL-1:0] bits,
  input  logic [LW-1:0] off,
  output logic          hit,
  output logic [LW-1:0] line
);
  pick_t r;
  always_comb r = hi_pick(bits, off);
  assign hit  = r.hit;
  assign line = r.line;
endmodule

// File: rtl/picr_init_fsm.sv
module picr_init_fsm
  import picr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          mask_wr,
  output logic [DW-1:0] vec_base,
  output logic          nested_mode,
  output logic          auto_eoi
);
  init_st_e st_q;
  logic     want4_q;

  assign busy    = (st_q != ST_RUN);
  assign mask_wr = (op == OP_DATA) && (st_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      want4_q     <= 1'b0;
      vec_base    <= '0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
    end else if (op == OP_INIT) begin
      st_q        <= ST_BASE;
      want4_q     <= wdata[0];
      vec_base    <= '0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
    end else if (op == OP_DATA) begin
      unique case (st_q)
        ST_BASE: begin
          vec_base <= wdata & BASE_KEEP;
          st_q     <= ST_W3;
        end
        ST_W3:   st_q <= want4_q ? ST_W4 : ST_RUN;
        ST_W4: begin
          nested_mode <= wdata[4];
          auto_eoi    <= wdata[1];
          st_q        <= ST_RUN;
        end
        default: ;
      endcase
    end
  end

  // R3: base word keeps only the upper five bits
  p_base_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DATA && st_q == ST_BASE) |=> (vec_base == ($past(wdata) & BASE_KEEP) && busy));
  // R3: a 2-word setup returns to normal operation after the second data word
  p_short_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DATA && st_q == ST_W3 && !want4_q) |=> !busy);
endmodule

// File: rtl/picr_cmd_port.sv
module picr_cmd_port
  import picr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NL-1:0] req_set,
  input  logic [NL-1:0] svc_set,
  input  logic          res_valid,
  input  logic [LW-1:0] res_line,
  output logic [NL-1:0] irr,
  output logic [NL-1:0] isr,
  output logic [NL-1:0] imr,
  output logic [LW-1:0] prio_off,
  output logic [DW-1:0] vec_base,
  output logic          nested_mode,
  output logic          auto_eoi,
  output logic          rot_on_aeoi,
  output logic          special_mask,
  output logic          cfg_busy,
  output logic          int_drop
);
  op_e           op;
  logic          mask_wr;
  logic          pk_hit;
  logic [LW-1:0] pk_line;
  logic          poll_q, rsel_q;

  // named events for the assertions
  logic          init_wr, eoi_cmd, poll_rd, poll_take;
  logic [NL-1:0] isr_clr, irr_clr;

  picr_decode u_dec (.wr_en(wr_en), .addr(addr), .wdata(wdata), .op(op));

  picr_isr_pick u_pick (.bits(isr), .off(prio_off), .hit(pk_hit), .line(pk_line));

  picr_init_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .op(op), .wdata(wdata), .busy(cfg_busy),
    .mask_wr(mask_wr), .vec_base(vec_base), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi)
  );

  assign init_wr   = (op == OP_INIT);
  assign eoi_cmd   = (op == OP_EOI) || (op == OP_EOI_ROT);
  assign poll_rd   = rd_en && poll_q;
  assign poll_take = poll_rd && res_valid;

  always_comb begin
    isr_clr = '0;
    if (eoi_cmd && pk_hit)                      isr_clr |= line_bit(pk_line);
    if (op == OP_SEOI || op == OP_SEOI_ROT)     isr_clr |= line_bit(wdata[LW-1:0]);
    if (poll_take)                              isr_clr |= line_bit(res_line);
    irr_clr = poll_take ? line_bit(res_line) : '0;
  end

  always_comb begin
    if (poll_rd)   rdata = res_valid ? DW'(res_line) : DW'(NL - 1);
    else if (addr) rdata = imr;
    else           rdata = rsel_q ? isr : irr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= '0; prio_off <= '0;
      poll_q <= 1'b0; rsel_q <= 1'b0; special_mask <= 1'b0;
      rot_on_aeoi <= 1'b0; int_drop <= 1'b0;
    end else begin
      int_drop <= init_wr;
      if (init_wr) begin
        irr <= '0; isr <= '0; imr <= '0; prio_off <= '0;
        poll_q <= 1'b0; rsel_q <= 1'b0; special_mask <= 1'b0;
        rot_on_aeoi <= 1'b0;
      end else begin
        irr <= (irr | req_set) & ~irr_clr;
        isr <= (isr | svc_set) & ~isr_clr;
        if (mask_wr) imr <= wdata;
        unique case (op)
          OP_MODE: begin
            if (wdata[2]) poll_q       <= 1'b1;
            if (wdata[1]) rsel_q       <= wdata[0];
            if (wdata[6]) special_mask <= wdata[5];
          end
          OP_ROT_CLR:  rot_on_aeoi <= 1'b0;
          OP_ROT_SET:  rot_on_aeoi <= 1'b1;
          OP_EOI_ROT:  if (pk_hit) prio_off <= past_line(pk_line);
          OP_SETPRI,
          OP_SEOI_ROT: prio_off <= past_line(wdata[LW-1:0]);
          default: ;
        endcase
        if (poll_rd) poll_q <= 1'b0;
      end
    end
  end

  // R2: setup start wipes the registers and pulses the drop output
  p_init_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (irr == '0 && isr == '0 && imr == '0 && prio_off == '0 && int_drop && cfg_busy));
  // R4: mask load in normal operation
  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DATA && !cfg_busy) |=> imr == $past(wdata));
  // R3: data words during setup leave the mask alone
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DATA && cfg_busy) |=> $stable(imr));
  // R7: end-of-interrupt on an empty in-service register has no effect
  p_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && isr == '0 && svc_set == '0) |=> (isr == '0 && $stable(prio_off)));
  // R11: a poll read disarms the poll
  p_poll_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |=> !poll_q);
  // R11: the polled line leaves both request and in-service
  p_poll_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !init_wr) |=> (!irr[$past(res_line)] && !isr[$past(res_line)]));
  // R2: the drop pulse only follows a setup start
  p_drop_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_drop) |-> $past(init_wr));
endmodule

// File: tb/sim_picr_cmd_port.sv
`timescale 1ns/100ps
module sim_picr_cmd_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, addr = 0, res_valid = 0;
  logic [7:0] wdata = 0, req_set = 0, svc_set = 0;
  logic [2:0] res_line = 0;
  logic [7:0] rdata, irr, isr, imr, vec_base;
  logic [2:0] prio_off;
  logic nested_mode, auto_eoi, rot_on_aeoi, special_mask, cfg_busy, int_drop;

  int checks = 0, errors = 0;

  // reference state
  logic [7:0] m_irr, m_isr, m_imr, m_base;
  logic [2:0] m_off;
  int m_st;
  logic m_w4, m_poll, m_rsel, m_smm, m_rot, m_aeoi, m_nest, m_drop;

  always #2 clk = ~clk;

  picr_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_set(req_set), .svc_set(svc_set),
    .res_valid(res_valid), .res_line(res_line), .irr(irr), .isr(isr), .imr(imr),
    .prio_off(prio_off), .vec_base(vec_base), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask),
    .cfg_busy(cfg_busy), .int_drop(int_drop)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // priority scan from the top: the last hit is the best one
  function automatic int ref_best(logic [7:0] v, logic [2:0] off);
    int best = -1;
    for (int p = 7; p >= 0; p--)
      if (v[(off + p) % 8]) best = (off + p) % 8;
    return best;
  endfunction

  function automatic logic [7:0] ref_read(logic a, logic rv, logic [2:0] rl);
    if (m_poll) return rv ? {5'd0, rl} : 8'd7;
    if (a) return m_imr;
    return m_rsel ? m_isr : m_irr;
  endfunction

  task automatic model_reset();
    m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_off = 0; m_st = 0;
    m_w4 = 0; m_poll = 0; m_rsel = 0; m_smm = 0; m_rot = 0; m_aeoi = 0;
    m_nest = 0; m_drop = 0;
  endtask

  task automatic model_edge(logic w, logic r, logic a, logic [7:0] d,
                            logic [7:0] rs, logic [7:0] sv, logic rv, logic [2:0] rl);
    logic [7:0] ni, ns;
    int h;
    ni = m_irr | rs; ns = m_isr | sv; m_drop = 0;
    h = ref_best(m_isr, m_off);
    if (w && !a && d[4]) begin
      model_reset();
      m_w4 = d[0]; m_st = 1; m_drop = 1;
      return;
    end
    if (w && !a && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smm = d[5];
    end else if (w && !a) begin
      case (d[7:5])
        3'd0: m_rot = 0;
        3'd4: m_rot = 1;
        3'd1, 3'd5: if (h >= 0) begin
          ns[h] = 1'b0;
          if (d[7]) m_off = 3'((h + 1) % 8);
        end
        3'd3: ns[d[2:0]] = 1'b0;
        3'd6: m_off = d[2:0] + 3'd1;
        3'd7: begin ns[d[2:0]] = 1'b0; m_off = d[2:0] + 3'd1; end
        default: ;
      endcase
    end else if (w && a) begin
      case (m_st)
        0: m_imr = d;
        1: begin m_base = {d[7:3], 3'b000}; m_st = 2; end
        2: m_st = m_w4 ? 3 : 0;
        default: begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
      endcase
    end
    if (r && m_poll) begin
      if (rv) begin ni[rl] = 1'b0; ns[rl] = 1'b0; end
      m_poll = 0;
    end
    m_irr = ni; m_isr = ns;
  endtask

  task automatic compare_outputs();
    chk("R12 irr", irr, m_irr);
    chk("R7 isr", isr, m_isr);
    chk("R4 imr", imr, m_imr);
    chk("R8 offset", {5'd0, prio_off}, {5'd0, m_off});
    chk("R3 base", vec_base, m_base);
    chk("R3 nested/aeoi", {6'd0, nested_mode, auto_eoi}, {6'd0, m_nest, m_aeoi});
    chk("R6 rotate", {7'd0, rot_on_aeoi}, {7'd0, m_rot});
    chk("R5 special mask", {7'd0, special_mask}, {7'd0, m_smm});
    chk("R3 busy", {7'd0, cfg_busy}, {7'd0, m_st != 0});
    chk("R2 drop", {7'd0, int_drop}, {7'd0, m_drop});
  endtask

  task automatic step(logic w, logic r, logic a, logic [7:0] d,
                      logic [7:0] rs, logic [7:0] sv, logic rv, logic [2:0] rl);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; req_set = rs; svc_set = sv;
    res_valid = rv; res_line = rl;
    #0.5;
    if (r) chk(m_poll ? "R11 poll read" : "R10 reg read", rdata, ref_read(a, rv, rl));
    @(posedge clk);
    model_edge(w, r, a, d, rs, sv, rv, rl);
    #0.5;
    compare_outputs();
    @(negedge clk);
    wr_en = 0; rd_en = 0; req_set = 0; svc_set = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d); step(1, 0, a, d, 0, 0, 0, 0); endtask
  task automatic rd(logic a, logic rv, logic [2:0] rl); step(0, 1, a, 0, 0, 0, rv, rl); endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    model_reset();
    #7 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    compare_outputs();
    rd(0, 0, 0);
    // R2/R3 4-word setup
    step(1, 0, 0, 8'h11, 8'hFF, 8'hFF, 0, 0);
    wr(1, 8'h00);          // R3 base masked -> mask untouched
    wr(1, 8'h00);
    wr(1, 8'h12);          // R3 fourth word: nested and auto-eoi
    wr(1, 8'hA5);          // R4 mask load
    rd(1, 0, 0);           // R10 mask read
    wr(0, 8'h10); wr(1, 8'h6F); wr(1, 8'h55);    // R3 2-word setup
    // R12 sets, R7 eoi order
    step(0, 0, 0, 0, 8'h81, 8'h28, 0, 0);
    wr(0, 8'h0B); rd(0, 0, 0);                   // R5 select in-service, R10
    wr(0, 8'h20);          // R7 clears line 3
    wr(0, 8'hC4);          // R9 offset 5
    step(0, 0, 0, 0, 0, 8'h11, 0, 0);
    wr(0, 8'hA0);          // R8 rotating eoi picks line 5
    wr(0, 8'h20); wr(0, 8'h20); wr(0, 8'h20);    // R7 drain, then empty
    wr(0, 8'hA0);          // R7 empty: offset holds
    wr(0, 8'h80); wr(0, 8'h40); wr(0, 8'h00);    // R6 rotate set, nop, clear
    step(0, 0, 0, 0, 0, 8'hC0, 0, 0);
    wr(0, 8'h66); wr(0, 8'hE7);                  // R9 specific clear, clear+rotate
    wr(0, 8'h68); wr(0, 8'h48);                  // R5 special mask on/off
    wr(0, 8'h0C); rd(1, 0, 0);                   // R11 poll, nothing pending
    wr(0, 8'h0C); rd(0, 1, 3'd7);                // R11 poll with a winner
    rd(0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [7:0] d, rs, sv;
      k = $urandom % 100;
      d = 8'($urandom);
      rs = 8'($urandom & $urandom & $urandom);
      sv = 8'($urandom & $urandom & $urandom);
      if (k < 3)       step(1, 0, 0, (d & 8'hEF) | 8'h10, rs, sv, 0, 0);
      else if (k < 18) step(1, 0, 0, (d & 8'hE7) | 8'h08, rs, sv, 0, 0);
      else if (k < 42) step(1, 0, 0, d & 8'hE7, rs, sv, 0, 0);
      else if (k < 58) step(1, 0, 1, d, rs, sv, 0, 0);
      else if (k < 85) step(0, 1, 1'($urandom), 0, rs, sv, 1'($urandom), 3'($urandom));
      else             step(0, 0, 0, 0, rs, sv, 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule